// File: doc/BRIEF.md
# Dot-Matrix Row Multiplex Scanner

This block drives a row-multiplexed LED matrix made of several 5x7 dot characters placed side by side. A free-running clock is divided by a fixed prescaler. Each prescaler tick advances a seven-state row counter. For the row being lit, the block takes each digit's character code and cursor flag from the storage block beside it. It looks up that digit's five column dots in a character pattern function and drives a one-hot row select together with the full column vector.

The block applies three display controls on top of the stored data. A per-digit cursor flag, gated by a global cursor enable, replaces the glyph with every dot lit at half brightness. The half brightness comes from lighting cursor digits only on every second scan frame. A live active-low blank input turns every column off for as long as it is held. A one-cycle frame-start pulse marks each wrap of the row counter, and the storage block uses it to pace its clear sweep. The pattern function holds only a few placeholder glyphs. Every other code shows as blank.

Top module: `dmx_row_scanner`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `row_sel`, `col_out` and `frame_start` are all zero.
- R2: Once running, `row_sel` is one-hot active high. Row r is bit r. Each row is held for PRESCALE clock cycles, and the rows repeat in the order 0,1,...,6,0.
- R3: `frame_start` is high for exactly one cycle, the first cycle in which `row_sel` shows row 0 after row 6. It does not pulse for the first frame after reset.
- R4: Digit d takes its code from `char_codes[7d+6:7d]` and its cursor flag from `cursor_mask[d]`. It drives `col_out[5d+4:5d]`, where glyph column c is bit 5d+c. Outputs reflect the inputs present at the clock edge that updates them.
- R5: Defined glyphs, listed as column bits 4..0 per row:
  - 0x2D: 11111 on row 3, and 00000 on every other row.
  - 0x7C: 00100 on every row.
  - 0x4F: 01110 on rows 0 and 6, and 10001 on rows 1 to 5.
  - 0x7F: 11111 on every row.
- R6: Any code other than those in R5 displays as all columns off on every row.
- R7: With `cursor_en` high and `cursor_mask[d]` high, digit d shows 11111 on every row of odd-numbered frames and 00000 on every row of even-numbered frames. Frames are counted from 0 at reset. Other digits are unaffected.
- R8: With `cursor_en` low, every digit shows its glyph whatever `cursor_mask` holds.
- R9: When a digit's cursor flag clears, its glyph is shown again from the next output update. The code is unchanged.
- R10: While `blank_n` is low, `col_out` is all zero and row scanning continues. After `blank_n` returns high, the glyphs are shown again from the next output update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running scan clock |
| rst | input | 1 | Synchronous active-high reset |
| char_codes | input | DIGITS*7 | Character code per digit |
| cursor_mask | input | DIGITS | Cursor flag per digit |
| cursor_en | input | 1 | Global cursor enable, active high |
| blank_n | input | 1 | Display blank, active low, not stored |
| row_sel | output | 7 | One-hot row select, active high |
| col_out | output | DIGITS*5 | Column dots, five per digit |
| frame_start | output | 1 | One-cycle pulse when the row counter wraps |

## Verification
The bench builds the scanner with PRESCALE set to 4 and DIGITS left at 4. A full seven-row frame then lasts 28 cycles, so several frames pass in a short run. This covers both the even and odd cursor frames, repeated frame-start pulses, and every row of each placeholder glyph. With four digits, all four defined glyphs can be shown side by side, and so can a mix of cursor and non-cursor digits.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int GLYPH_COLS = 5;
    localparam int GLYPH_ROWS = 7;
    localparam int CODE_W     = 7;
    localparam int ROW_W      = $clog2(GLYPH_ROWS);

    typedef logic [GLYPH_COLS-1:0] col_slice_t;
    typedef logic [ROW_W-1:0]      row_idx_t;
    typedef logic [GLYPH_ROWS-1:0] row_hot_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              cursor;
    } digit_in_t;

    typedef struct packed {
        row_idx_t row;
        logic     frame_odd;
        logic     wrapped;
    } scan_state_t;

    // Placeholder font: one row slice of a glyph, bit c = column c.
    function automatic col_slice_t glyph_slice(input logic [CODE_W-1:0] code,
                                               input row_idx_t row);
        col_slice_t s;
        s = '0;
        case (code)
            7'h2D: s = (row == row_idx_t'(3)) ? 5'b11111 : 5'b00000;
            7'h7C: s = 5'b00100;
            7'h4F: s = (row == row_idx_t'(0) || row == row_idx_t'(6)) ? 5'b01110 : 5'b10001;
            7'h7F: s = 5'b11111;
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic row_hot_t row_onehot(input row_idx_t row);
        return row_hot_t'(1) << row;
    endfunction

endpackage

// File: rtl/dmx_prescaler.sv
module dmx_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dmx_row_counter.sv
module dmx_row_counter
    import dmx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    output scan_state_t state
);
    localparam row_idx_t LAST_ROW = row_idx_t'(GLYPH_ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            state.wrapped <= 1'b0;
            if (tick) begin
                if (state.row == LAST_ROW) begin
                    state.row       <= '0;
                    state.frame_odd <= ~state.frame_odd;
                    state.wrapped   <= 1'b1;
                end else begin
                    state.row <= state.row + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dmx_col_builder.sv
module dmx_col_builder
    import dmx_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*CODE_W-1:0]     char_codes,
    input  logic [DIGITS-1:0]            cursor_mask,
    input  logic                         cursor_en,
    input  logic                         blank_n,
    input  row_idx_t                     row,
    input  logic                         frame_odd,
    output logic [DIGITS*GLYPH_COLS-1:0] cols
);
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        digit_in_t  din;
        col_slice_t slice;

        assign din.code   = char_codes[d*CODE_W +: CODE_W];
        assign din.cursor = cursor_mask[d];

        always_comb begin
            if (!blank_n) begin
                slice = '0;
            end else if (din.cursor && cursor_en) begin
                slice = frame_odd ? '1 : '0;
            end else begin
                slice = glyph_slice(din.code, row);
            end
        end

        assign cols[d*GLYPH_COLS +: GLYPH_COLS] = slice;
    end
endmodule

// File: rtl/dmx_row_scanner.sv
module dmx_row_scanner
    import dmx_pkg::*;
#(
    parameter int PRESCALE = 128,
    parameter int DIGITS   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DIGITS*CODE_W-1:0]     char_codes,
    input  logic [DIGITS-1:0]            cursor_mask,
    input  logic                         cursor_en,
    input  logic                         blank_n,
    output logic [GLYPH_ROWS-1:0]        row_sel,
    output logic [DIGITS*GLYPH_COLS-1:0] col_out,
    output logic                         frame_start
);
    localparam int COL_W = DIGITS * GLYPH_COLS;

    logic                 tick;
    scan_state_t          st;
    logic [COL_W-1:0]     cols_next;

    dmx_prescaler #(.DIV(PRESCALE)) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dmx_row_counter u_rows (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .state (st)
    );

    dmx_col_builder #(.DIGITS(DIGITS)) u_cols (
        .char_codes  (char_codes),
        .cursor_mask (cursor_mask),
        .cursor_en   (cursor_en),
        .blank_n     (blank_n),
        .row         (st.row),
        .frame_odd   (st.frame_odd),
        .cols        (cols_next)
    );

    // Row and columns leave through one register stage so they switch together.
    always_ff @(posedge clk) begin
        if (rst) begin
            row_sel     <= '0;
            col_out     <= '0;
            frame_start <= 1'b0;
        end else begin
            row_sel     <= row_onehot(st.row);
            col_out     <= cols_next;
            frame_start <= st.wrapped;
        end
    end
endmodule

// File: rtl/dmx_row_scanner_chk.sv
module dmx_row_scanner_chk
    import dmx_pkg::*;
#(
    parameter int PRESCALE = 128,
    parameter int DIGITS   = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [DIGITS*CODE_W-1:0]     char_codes,
    input logic [DIGITS-1:0]            cursor_mask,
    input logic                         cursor_en,
    input logic                         blank_n,
    input logic [GLYPH_ROWS-1:0]        row_sel,
    input logic [DIGITS*GLYPH_COLS-1:0] col_out,
    input logic                         frame_start
);
    assert_row_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $onehot(row_sel));

    assert_frame_on_row0_R3: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> row_sel[0]);

    assert_frame_single_R3: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_blank_dark_R10: assert property (@(posedge clk) disable iff (rst)
        !blank_n |=> (col_out == '0));

    for (genvar d = 0; d < DIGITS; d++) begin : g_chk
        assert_cursor_solid_R7: assert property (@(posedge clk) disable iff (rst)
            (cursor_mask[d] && cursor_en && blank_n)
            |=> (col_out[d*GLYPH_COLS +: GLYPH_COLS] == 5'h1F ||
                 col_out[d*GLYPH_COLS +: GLYPH_COLS] == 5'h00));

        assert_cursor_gated_R8: assert property (@(posedge clk) disable iff (rst)
            (!cursor_en && blank_n && char_codes[d*CODE_W +: CODE_W] == 7'h7F)
            |=> (col_out[d*GLYPH_COLS +: GLYPH_COLS] == 5'h1F));
    end
endmodule

bind dmx_row_scanner dmx_row_scanner_chk #(.PRESCALE(PRESCALE), .DIGITS(DIGITS)) u_chk (.*);

// File: tb/tb_dmx_row_scanner.sv
`timescale 1ns/1ps
module tb_dmx_row_scanner;
    localparam int P      = 4;
    localparam int ND     = 4;
    localparam int COL_W  = ND * 5;
    localparam int FRAME  = 7 * P;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ND*7-1:0]   char_codes = '0;
    logic [ND-1:0]     cursor_mask = '0;
    logic              cursor_en = 1'b0;
    logic              blank_n = 1'b1;
    logic [6:0]        row_sel;
    logic [COL_W-1:0]  col_out;
    logic              frame_start;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;

    typedef struct {
        logic [6:0]       row;
        logic [COL_W-1:0] col;
        logic             fs;
        string            tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    dmx_row_scanner #(.PRESCALE(P), .DIGITS(ND)) dut (
        .clk(clk), .rst(rst), .char_codes(char_codes), .cursor_mask(cursor_mask),
        .cursor_en(cursor_en), .blank_n(blank_n), .row_sel(row_sel),
        .col_out(col_out), .frame_start(frame_start)
    );

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    function automatic logic [4:0] ref_glyph(input logic [6:0] c, input int r);
        case (c)
            7'h2D: return (r == 3) ? 5'b11111 : 5'b00000;
            7'h7C: return 5'b00100;
            7'h4F: return (r == 0 || r == 6) ? 5'b01110 : 5'b10001;
            7'h7F: return 5'b11111;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one output update per call cycle, expectation pushed to the scoreboard.
    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int k;
            int r;
            int fr;
            @(posedge clk);
            #2;
            k  = edges - 1;
            r  = (k / P) % 7;
            fr = (k / FRAME) % 2;
            e.row = 7'(1) << r;
            e.fs  = (k > 0) && (k % FRAME == 0);
            e.tag = tag;
            for (int d = 0; d < ND; d++) begin
                logic [4:0] s;
                if (!blank_n)                         s = 5'b00000;
                else if (cursor_mask[d] && cursor_en) s = (fr == 1) ? 5'b11111 : 5'b00000;
                else                                  s = ref_glyph(char_codes[d*7 +: 7], r);
                e.col[d*5 +: 5] = s;
            end
            q.push_back(e);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R2 row_sel", 32'(row_sel), 32'(e.row));
            check("R3 frame_start", 32'(frame_start), 32'(e.fs));
            check(e.tag, 32'(col_out), 32'(e.col));
        end
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 reset row_sel", 32'(row_sel), 32'd0);
        check("R1 reset col_out", 32'(col_out), 32'd0);
        check("R1 reset frame_start", 32'(frame_start), 32'd0);
        @(posedge clk);
        #2;
        rst        = 1'b0;
        char_codes = {7'h7F, 7'h4F, 7'h7C, 7'h2D};
        cursor_en  = 1'b1;
        run(1, "R1 first cycle");
        run(2 * FRAME, "R4 R5 glyph columns");

        char_codes = {7'h7E, 7'h2E, 7'h00, 7'h41};
        run(FRAME, "R6 undefined codes");

        char_codes  = {7'h7F, 7'h4F, 7'h7C, 7'h2D};
        cursor_mask = 4'b0010;
        run(2 * FRAME + 3, "R7 cursor half brightness");

        cursor_en   = 1'b0;
        cursor_mask = 4'b1111;
        run(FRAME, "R8 cursor disabled");

        cursor_en   = 1'b1;
        cursor_mask = 4'b1001;
        run(FRAME + 2, "R7 two cursor digits");
        cursor_mask = 4'b0000;
        run(FRAME, "R9 cursor removed");

        cursor_mask = 4'b0100;
        blank_n     = 1'b0;
        run(FRAME + 5, "R10 blanked");
        blank_n = 1'b1;
        run(FRAME, "R10 blank released");

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule